// File: doc/BRIEF.md
# Programmable-Timing Memory Bus Initiator

This block is the initiating side of a two-channel memory bus: an address channel closed by a request/grant handshake, and a response channel closed by a valid/ready handshake. It takes one command at a time from a valid/ready command port. A command carries an address, a read/write flag, write data, byte enables and a transaction ID. The block presents the address phase and holds it until the target grants it. It then collects the response and reports the read data, the error flag and the response ID on a result port. Only one transaction is in flight at a time.

Four timing inputs shape each transaction, each counted in clock cycles: a lead delay before the request rises, a delay from the response valid rising to the response ready rising, a hold that keeps the response ready high after the response is taken, and an idle tail before the next command may enter. All four are captured when a command is accepted. Suggested settings are lead 0, ready delay 0, hold 1 and tail 1, with all byte enables set. The atomic-operation and user fields of the address phase are tied to zero. Each handshake output has a companion pin that carries its odd-parity bit.

The controller is an eight-state machine. The states are IDLE (command port open), LEAD (counting the lead delay), ADDR (request high, waiting for grant), WAIT (waiting for response valid; ready is already high when the ready delay is 0), RDLY (counting the ready delay), RDY (ready high until the response is taken), HOLD (ready kept high) and TAIL (idle gap). The transitions are:

- IDLE→LEAD or IDLE→ADDR on a legal command, depending on whether the lead delay is non-zero.
- LEAD→ADDR when the lead count ends.
- ADDR→WAIT on grant.
- WAIT→RDLY or WAIT→RDY on response valid when the ready delay is non-zero.
- WAIT→HOLD, TAIL or IDLE when a response is taken with a ready delay of 0.
- RDLY→RDY when the ready-delay count ends.
- RDY→HOLD, TAIL or IDLE when the response is taken.
- HOLD→TAIL or IDLE when the hold count ends.
- TAIL→IDLE when the tail count ends.

A command whose byte enables are all zero leaves the machine in IDLE and raises the reject flag.

Top module: `mbi_top`

## Requirements
- R1: While reset (active low) is asserted, and in the first cycle after it, req, rready and res_valid are 0 and cmd_ready is 1.
- R2: With lead delay N captured at acceptance, req is first high in the (N+1)th cycle after the accepting clock edge.
- R3: While req is high and gnt is low, req, addr, we, be, wdata and aid hold their values, which equal the accepted command. req is 0 in the cycle after the edge where req and gnt are both 1. atop and auser are 0.
- R4: With ready delay L, rready is first high L cycles after the cycle in which rvalid rises. When L is 0, rready is already high while the block waits for rvalid. req and rready are never high together.
- R5: A response is taken at an edge where rvalid and rready are both 1. In the next cycle res_valid is high for exactly one cycle with res_err = err and res_rid = rid. res_rdata equals rdata for a read (we = 0) and is 0 for a write (we = 1).
- R6: With hold H, rready stays high for exactly H cycles after the cycle in which the response was taken.
- R7: With tail T, cmd_ready stays low for exactly T cycles after rready falls, and is then 1.
- R8: cmd_ready is high only in the idle state. From the accepting edge until the tail ends it is 0, so at most one transaction is outstanding.
- R9: A command with cmd_be equal to 0 is accepted and discarded. cmd_bad is 1 for one cycle after the accepting edge, req stays 0 and cmd_ready stays 1.
- R10: reqpar is the inverse of req and rreadypar is the inverse of rready at all times.
- R11: The four timing inputs are sampled only at command acceptance; changing them during a transaction does not alter its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command port open (idle) |
| cmd_addr | input | AW | Command address |
| cmd_we | input | 1 | 1 = write, 0 = read |
| cmd_wdata | input | DW | Write data |
| cmd_be | input | DW/8 | Byte enables, must be non-zero |
| cmd_id | input | IDW | Transaction ID |
| lead_cyc | input | CW | Idle cycles before req rises |
| rdy_dly_cyc | input | CW | Cycles from rvalid rising to rready rising |
| rdy_hold_cyc | input | CW | Cycles rready stays high after the response |
| tail_cyc | input | CW | Idle cycles after rready falls |
| cmd_bad | output | 1 | One-cycle flag: command rejected (zero byte enables) |
| req | output | 1 | Address phase request |
| gnt | input | 1 | Address phase grant |
| addr | output | AW | Address |
| we | output | 1 | Write enable |
| be | output | DW/8 | Byte enables |
| wdata | output | DW | Write data |
| aid | output | IDW | Address phase ID |
| atop | output | 6 | Atomic operation, always 0 |
| auser | output | UW | Address user field, always 0 |
| reqpar | output | 1 | Odd parity of req |
| rvalid | input | 1 | Response valid |
| rready | output | 1 | Response ready |
| rreadypar | output | 1 | Odd parity of rready |
| rdata | input | DW | Response read data |
| err | input | 1 | Response error |
| rid | input | IDW | Response ID |
| res_valid | output | 1 | One-cycle result strobe |
| res_rdata | output | DW | Read data (0 for writes) |
| res_err | output | 1 | Captured error flag |
| res_rid | output | IDW | Captured response ID |

## Verification
The bench plays the target. It varies the grant delay and the response delay, and it measures each knob as a cycle count at the ports. An off-by-one in any of the four counters shows up as a req, rready or cmd_ready edge one cycle early or late. Mixing zero and non-zero values exposes a design that handles zero as 2^CW or skips the HOLD and TAIL states wrongly. A ready delay of 0 checks that rready is already high when rvalid arrives; a design that waited for rvalid first would take the response a cycle late. The bench also changes the knob inputs right after acceptance, which catches a design that reads them live instead of capturing them. Write responses arrive with junk read data that must come back as 0, and all-zero byte enables must be rejected without ever raising req.

// File: rtl/mbi_pkg.sv
package mbi_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_LEAD = 3'd1,
        ST_ADDR = 3'd2,
        ST_WAIT = 3'd3,
        ST_RDLY = 3'd4,
        ST_RDY  = 3'd5,
        ST_HOLD = 3'd6,
        ST_TAIL = 3'd7
    } mbi_phase_t;

    localparam int unsigned ATOP_W = 6;

endpackage

// File: rtl/mbi_cmd_latch.sv
module mbi_cmd_latch #(
    parameter int unsigned AW  = 32,
    parameter int unsigned DW  = 32,
    parameter int unsigned IDW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [AW-1:0]   in_addr,
    input  logic            in_we,
    input  logic [DW-1:0]   in_wdata,
    input  logic [DW/8-1:0] in_be,
    input  logic [IDW-1:0]  in_id,
    output logic            in_be_zero,
    output logic [AW-1:0]   q_addr,
    output logic            q_we,
    output logic [DW-1:0]   q_wdata,
    output logic [DW/8-1:0] q_be,
    output logic [IDW-1:0]  q_id
);
    localparam int unsigned BEW = DW / 8;

    // A command with no byte lane selected is illegal.
    assign in_be_zero = (in_be == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_addr  <= '0;
            q_we    <= 1'b0;
            q_wdata <= '0;
            q_be    <= '0;
            q_id    <= '0;
        end else if (load && !in_be_zero) begin
            q_addr  <= in_addr;
            q_we    <= in_we;
            q_wdata <= in_wdata;
            q_be    <= in_be[BEW-1:0];
            q_id    <= in_id;
        end
    end
endmodule

// File: rtl/mbi_phase_fsm.sv
module mbi_phase_fsm
    import mbi_pkg::*;
#(
    parameter int unsigned CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic          cmd_be_zero,
    input  logic [CW-1:0] lead_cyc,
    input  logic [CW-1:0] rdy_dly_cyc,
    input  logic [CW-1:0] rdy_hold_cyc,
    input  logic [CW-1:0] tail_cyc,
    input  logic          gnt,
    input  logic          rvalid,
    output logic          cmd_ready,
    output logic          cmd_take,
    output logic          cmd_bad,
    output logic          req,
    output logic          rready,
    output logic          resp_take
);
    localparam logic [CW-1:0] ONE = CW'(1);

    mbi_phase_t    st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] dly_q, hold_q, tail_q;
    logic          bad_q, bad_d;
    logic          resp_done, hold_done;

    assign cmd_take = (st_q == ST_IDLE) && cmd_valid;

    // Next-state logic
    always_comb begin
        st_d      = st_q;
        cnt_d     = cnt_q;
        bad_d     = 1'b0;
        resp_done = 1'b0;
        hold_done = 1'b0;
        resp_take = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (cmd_valid) begin
                    if (cmd_be_zero) begin
                        bad_d = 1'b1;
                    end else if (lead_cyc == '0) begin
                        st_d = ST_ADDR;
                    end else begin
                        st_d  = ST_LEAD;
                        cnt_d = lead_cyc;
                    end
                end
            end
            ST_LEAD: begin
                if (cnt_q == ONE) st_d = ST_ADDR;
                else              cnt_d = cnt_q - ONE;
            end
            ST_ADDR: begin
                if (gnt) st_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (rvalid) begin
                    if (dly_q == '0) begin
                        resp_take = 1'b1;
                        resp_done = 1'b1;
                    end else if (dly_q == ONE) begin
                        st_d = ST_RDY;
                    end else begin
                        st_d  = ST_RDLY;
                        cnt_d = dly_q - ONE;
                    end
                end
            end
            ST_RDLY: begin
                if (cnt_q == ONE) st_d = ST_RDY;
                else              cnt_d = cnt_q - ONE;
            end
            ST_RDY: begin
                if (rvalid) begin
                    resp_take = 1'b1;
                    resp_done = 1'b1;
                end
            end
            ST_HOLD: begin
                if (cnt_q == ONE) hold_done = 1'b1;
                else              cnt_d = cnt_q - ONE;
            end
            ST_TAIL: begin
                if (cnt_q == ONE) st_d = ST_IDLE;
                else              cnt_d = cnt_q - ONE;
            end
        endcase

        // Shared exit from the response phase
        if (resp_done) begin
            if (hold_q != '0) begin
                st_d  = ST_HOLD;
                cnt_d = hold_q;
            end else if (tail_q != '0) begin
                st_d  = ST_TAIL;
                cnt_d = tail_q;
            end else begin
                st_d = ST_IDLE;
            end
        end
        if (hold_done) begin
            if (tail_q != '0) begin
                st_d  = ST_TAIL;
                cnt_d = tail_q;
            end else begin
                st_d = ST_IDLE;
            end
        end
    end

    // State register, counter and captured knobs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            dly_q  <= '0;
            hold_q <= '0;
            tail_q <= '0;
            bad_q  <= 1'b0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            bad_q <= bad_d;
            if (cmd_take && !cmd_be_zero) begin
                dly_q  <= rdy_dly_cyc;
                hold_q <= rdy_hold_cyc;
                tail_q <= tail_cyc;
            end
        end
    end

    // Outputs decoded from state
    always_comb begin
        cmd_ready = (st_q == ST_IDLE);
        req       = (st_q == ST_ADDR);
        rready    = (st_q == ST_RDY) || (st_q == ST_HOLD) ||
                    ((st_q == ST_WAIT) && (dly_q == '0));
        cmd_bad   = bad_q;
    end
endmodule

// File: rtl/mbi_result.sv
module mbi_result #(
    parameter int unsigned DW  = 32,
    parameter int unsigned IDW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           take,
    input  logic           is_write,
    input  logic [DW-1:0]  rdata,
    input  logic           err,
    input  logic [IDW-1:0] rid,
    output logic           res_valid,
    output logic [DW-1:0]  res_rdata,
    output logic           res_err,
    output logic [IDW-1:0] res_rid
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_rdata <= '0;
            res_err   <= 1'b0;
            res_rid   <= '0;
        end else begin
            res_valid <= take;
            if (take) begin
                res_rdata <= is_write ? '0 : rdata;
                res_err   <= err;
                res_rid   <= rid;
            end
        end
    end
endmodule

// File: rtl/mbi_top.sv
module mbi_top
    import mbi_pkg::*;
#(
    parameter int unsigned AW  = 32,
    parameter int unsigned DW  = 32,
    parameter int unsigned IDW = 4,
    parameter int unsigned UW  = 2,
    parameter int unsigned CW  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [AW-1:0]     cmd_addr,
    input  logic              cmd_we,
    input  logic [DW-1:0]     cmd_wdata,
    input  logic [DW/8-1:0]   cmd_be,
    input  logic [IDW-1:0]    cmd_id,
    input  logic [CW-1:0]     lead_cyc,
    input  logic [CW-1:0]     rdy_dly_cyc,
    input  logic [CW-1:0]     rdy_hold_cyc,
    input  logic [CW-1:0]     tail_cyc,
    output logic              cmd_bad,
    output logic              req,
    input  logic              gnt,
    output logic [AW-1:0]     addr,
    output logic              we,
    output logic [DW/8-1:0]   be,
    output logic [DW-1:0]     wdata,
    output logic [IDW-1:0]    aid,
    output logic [ATOP_W-1:0] atop,
    output logic [UW-1:0]     auser,
    output logic              reqpar,
    input  logic              rvalid,
    output logic              rready,
    output logic              rreadypar,
    input  logic [DW-1:0]     rdata,
    input  logic              err,
    input  logic [IDW-1:0]    rid,
    output logic              res_valid,
    output logic [DW-1:0]     res_rdata,
    output logic              res_err,
    output logic [IDW-1:0]    res_rid
);
    logic cmd_take;
    logic be_zero;
    logic resp_take;

    mbi_cmd_latch #(.AW(AW), .DW(DW), .IDW(IDW)) u_cmd (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (cmd_take),
        .in_addr    (cmd_addr),
        .in_we      (cmd_we),
        .in_wdata   (cmd_wdata),
        .in_be      (cmd_be),
        .in_id      (cmd_id),
        .in_be_zero (be_zero),
        .q_addr     (addr),
        .q_we       (we),
        .q_wdata    (wdata),
        .q_be       (be),
        .q_id       (aid)
    );

    mbi_phase_fsm #(.CW(CW)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_valid    (cmd_valid),
        .cmd_be_zero  (be_zero),
        .lead_cyc     (lead_cyc),
        .rdy_dly_cyc  (rdy_dly_cyc),
        .rdy_hold_cyc (rdy_hold_cyc),
        .tail_cyc     (tail_cyc),
        .gnt          (gnt),
        .rvalid       (rvalid),
        .cmd_ready    (cmd_ready),
        .cmd_take     (cmd_take),
        .cmd_bad      (cmd_bad),
        .req          (req),
        .rready       (rready),
        .resp_take    (resp_take)
    );

    mbi_result #(.DW(DW), .IDW(IDW)) u_res (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (resp_take),
        .is_write  (we),
        .rdata     (rdata),
        .err       (err),
        .rid       (rid),
        .res_valid (res_valid),
        .res_rdata (res_rdata),
        .res_err   (res_err),
        .res_rid   (res_rid)
    );

    // Unused address-phase extensions are tied off; parity pins are odd parity.
    assign atop      = '0;
    assign auser     = '0;
    assign reqpar    = ~req;
    assign rreadypar = ~rready;
endmodule

// File: rtl/mbi_checker.sv
module mbi_checker #(
    parameter int unsigned AW  = 32,
    parameter int unsigned DW  = 32,
    parameter int unsigned IDW = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cmd_valid,
    input logic            cmd_ready,
    input logic [DW/8-1:0] cmd_be,
    input logic            cmd_bad,
    input logic            req,
    input logic            gnt,
    input logic [AW-1:0]   addr,
    input logic            we,
    input logic [DW/8-1:0] be,
    input logic [DW-1:0]   wdata,
    input logic [IDW-1:0]  aid,
    input logic            rvalid,
    input logic            rready,
    input logic            res_valid
);
    assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req && !gnt |=> req && $stable(addr) && $stable(we) && $stable(be)
                        && $stable(wdata) && $stable(aid));

    assert_req_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req && gnt |=> !req);

    assert_no_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(req && rready));

    assert_res_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid && rready |=> res_valid);

    assert_res_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(rvalid && rready));

    assert_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !req && !rready);

    assert_reject_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready && (cmd_be == '0) |=> cmd_bad && !req && cmd_ready);
endmodule

bind mbi_top mbi_checker #(.AW(AW), .DW(DW), .IDW(IDW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_be    (cmd_be),
    .cmd_bad   (cmd_bad),
    .req       (req),
    .gnt       (gnt),
    .addr      (addr),
    .we        (we),
    .be        (be),
    .wdata     (wdata),
    .aid       (aid),
    .rvalid    (rvalid),
    .rready    (rready),
    .res_valid (res_valid)
);

// File: tb/mbi_top_bench.sv
module mbi_top_bench;
    localparam int AW = 32, DW = 32, IDW = 4, UW = 2, CW = 4, BEW = DW / 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic cmd_valid = 0, cmd_we = 0;
    logic [AW-1:0] cmd_addr = '0;
    logic [DW-1:0] cmd_wdata = '0;
    logic [BEW-1:0] cmd_be = '1;
    logic [IDW-1:0] cmd_id = '0;
    logic [CW-1:0] lead_cyc = 0, rdy_dly_cyc = 0, rdy_hold_cyc = 1, tail_cyc = 1;
    logic gnt = 0, rvalid = 0, err = 0;
    logic [DW-1:0] rdata = '0;
    logic [IDW-1:0] rid = '0;
    logic cmd_ready, cmd_bad, req, we, reqpar, rready, rreadypar, res_valid, res_err;
    logic [AW-1:0] addr;
    logic [BEW-1:0] be;
    logic [DW-1:0] wdata, res_rdata;
    logic [IDW-1:0] aid, res_rid;
    logic [5:0] atop;
    logic [UW-1:0] auser;

    mbi_top #(.AW(AW), .DW(DW), .IDW(IDW), .UW(UW), .CW(CW)) u_mbi_top (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_addr(cmd_addr), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata), .cmd_be(cmd_be),
        .cmd_id(cmd_id), .lead_cyc(lead_cyc), .rdy_dly_cyc(rdy_dly_cyc),
        .rdy_hold_cyc(rdy_hold_cyc), .tail_cyc(tail_cyc), .cmd_bad(cmd_bad),
        .req(req), .gnt(gnt), .addr(addr), .we(we), .be(be), .wdata(wdata), .aid(aid),
        .atop(atop), .auser(auser), .reqpar(reqpar), .rvalid(rvalid), .rready(rready),
        .rreadypar(rreadypar), .rdata(rdata), .err(err), .rid(rid),
        .res_valid(res_valid), .res_rdata(res_rdata), .res_err(res_err), .res_rid(res_rid)
    );

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Expected read-data seen on the result port
    function automatic logic [DW-1:0] exp_rdata(input logic is_wr, input logic [DW-1:0] d);
        return is_wr ? '0 : d;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic run_txn(input logic [AW-1:0] a, input logic w, input logic [DW-1:0] d,
                           input logic [BEW-1:0] b, input logic [IDW-1:0] id,
                           input int n, input int l, input int h, input int t,
                           input int g, input int v, input logic e, input logic [DW-1:0] rd);
        int c;
        @(negedge clk);
        chk(cmd_ready == 1'b1, "R8 ready before command", cmd_ready, 1);
        cmd_valid = 1; cmd_addr = a; cmd_we = w; cmd_wdata = d; cmd_be = b; cmd_id = id;
        lead_cyc = CW'(n); rdy_dly_cyc = CW'(l); rdy_hold_cyc = CW'(h); tail_cyc = CW'(t);
        @(negedge clk);
        cmd_valid = 0;
        // R11: scramble knobs after acceptance
        lead_cyc = CW'(n + 5); rdy_dly_cyc = CW'(l + 3); rdy_hold_cyc = CW'(h + 4); tail_cyc = CW'(t + 2);
        chk(cmd_ready == 1'b0, "R8 busy after accept", cmd_ready, 0);
        c = 1;
        while (!req && c < 60) begin @(negedge clk); c++; end
        chk(c == n + 1, "R2 lead delay", c, n + 1);
        chk(addr == a && we == w && wdata == d && be == b && aid == id, "R3 fields", addr, a);
        chk(atop == 0 && auser == 0, "R3 tied fields", atop, 0);
        chk(reqpar == ~req, "R10 reqpar", reqpar, ~req);
        for (int k = 0; k < g; k++) begin
            @(negedge clk);
            chk(req == 1'b1 && addr == a && aid == id, "R3 held before grant", req, 1);
        end
        gnt = 1;
        @(negedge clk);
        gnt = 0;
        chk(req == 1'b0, "R3 req drops after grant", req, 0);
        for (int k = 0; k < v; k++) begin
            chk(rready == (l == 0), "R4 rready while waiting", rready, (l == 0));
            @(negedge clk);
        end
        rvalid = 1; rdata = rd; err = e; rid = id;
        c = 0;
        while (!rready && c < 60) begin @(negedge clk); c++; end
        chk(c == l, "R4 ready delay", c, l);
        chk(rreadypar == ~rready, "R10 rreadypar", rreadypar, ~rready);
        @(negedge clk);
        rvalid = 0; rdata = 32'hDEAD_BEEF; err = 0; rid = ~id;
        chk(res_valid == 1'b1, "R5 result strobe", res_valid, 1);
        chk(res_rdata == exp_rdata(w, rd), "R5 result data", res_rdata, exp_rdata(w, rd));
        chk(res_err == e && res_rid == id, "R5 err/rid", {res_err, res_rid}, {e, id});
        c = 0;
        while (rready && c < 60) begin
            @(negedge clk); c++;
            if (c == 1) chk(res_valid == 1'b0, "R5 strobe one cycle", res_valid, 0);
        end
        chk(c == h, "R6 hold", c, h);
        c = 0;
        while (!cmd_ready && c < 60) begin @(negedge clk); c++; end
        chk(c == t, "R7 tail", c, t);
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        chk(req == 0 && rready == 0 && res_valid == 0 && cmd_ready == 1, "R1 in reset", req, 0);
        rst_n = 1;
        @(negedge clk);
        chk(req == 0 && rready == 0 && res_valid == 0 && cmd_ready == 1, "R1 after reset", rready, 0);
        chk(reqpar == 1 && rreadypar == 1, "R10 idle parity", {reqpar, rreadypar}, 2'b11);

        // Directed: default knobs, read
        run_txn(32'h1000, 0, 32'h0, '1, 4'h3, 0, 0, 1, 1, 0, 0, 0, 32'hCAFE_0001);
        // Directed: all zero knobs, write with junk response data and error
        run_txn(32'h2004, 1, 32'h1234_5678, 4'b0011, 4'hA, 0, 0, 0, 0, 0, 2, 1, 32'hFFFF_FFFF);
        // Directed: long delays
        run_txn(32'h3008, 0, 32'h0, 4'b1000, 4'h5, 7, 6, 5, 4, 3, 3, 0, 32'h0BAD_F00D);

        // R9: zero byte enables rejected
        @(negedge clk);
        cmd_valid = 1; cmd_be = '0; cmd_id = 4'h7;
        @(negedge clk);
        cmd_valid = 0; cmd_be = '1;
        chk(cmd_bad == 1 && req == 0 && cmd_ready == 1, "R9 reject", {cmd_bad, req, cmd_ready}, 3'b101);
        @(negedge clk);
        chk(cmd_bad == 0 && req == 0, "R9 flag clears", cmd_bad, 0);

        for (int i = 0; i < 60; i++) begin
            logic [BEW-1:0] b;
            b = BEW'($urandom_range(1, (1 << BEW) - 1));
            run_txn($urandom, 1'($urandom), $urandom, b, IDW'($urandom),
                    $urandom_range(0, 4), $urandom_range(0, 4), $urandom_range(0, 4),
                    $urandom_range(0, 4), $urandom_range(0, 3), $urandom_range(0, 3),
                    1'($urandom), $urandom);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule